// File: doc/BRIEF.md
# SPI Flash Wait-Idle Poller

This block sits beside a single-line SPI flash master. It takes over once an erase, program or status-write operation has been issued to the flash. It then polls the flash status register over and over until the write-in-progress flag reads clear, and signals completion with a one-cycle pulse. Each poll is one chip-select frame with four phases: a command of 8 or 16 bits, an optional all-zero address of programmable length, an optional dummy phase of programmable length, and an 8-bit status read.

The controller pulses `start_i` with an operation code and presents a 28-bit control word. That word is captured at start and used for the whole poll. A control word with its enable bit clear makes the block finish at once, with no serial traffic. The serial clock is the system clock divided by a parameter. Frames use SPI mode 0 and send the most significant bit first.

Top module: `flash_idle_poller`

## Requirements
- R1: After the synchronous active-high reset, `cs_n_o`=1, `sclk_o`=0, `mosi_o`=0, `busy_o`=0 and `done_o`=0.
- R2: A `start_i` pulse with `op_i` equal to 1 (erase), 2 (program) or 3 (status write) and control bit 16 (enable) set is accepted. In the next cycle `busy_o`=1 and `cs_n_o`=0. With `op_i`=0 the pulse has no effect.
- R3: When a start is accepted with control bit 16 clear, `done_o` is high for exactly the next cycle. `busy_o` stays low and `cs_n_o` stays high.
- R4: If control bit 17 is set, the command phase sends control bits [15:0]. If bit 17 is clear, it sends only bits [7:0]. In both cases the most significant bit goes first, MOSI changes while SCLK is low, and MISO is sampled on the rising SCLK edge.
- R5: If control bit 18 is set, an address phase of all-zero bits follows the command. Its length is (control bits [20:19] + 1) SCLK cycles. If bit 18 is clear there is no address phase, whatever bits [20:19] hold.
- R6: If control bit 21 is set, a dummy phase of control bits [27:22] SCLK cycles follows, with MOSI held at 0. A length of 0, or bit 21 clear, gives no dummy phase.
- R7: Each frame ends with 8 status bits read most significant bit first. If status bit 0 is 1, chip select goes high for at least 2 SCLK periods (4*CLK_DIV system clocks) and the whole frame is repeated.
- R8: If status bit 0 is 0, `cs_n_o` rises and `done_o` pulses for one cycle, in the same cycle that `busy_o` falls. Status bits [7:1] have no effect.
- R9: Each SCLK half period lasts CLK_DIV system clocks. SCLK is low, and MOSI is 0, whenever chip select is high.
- R10: A start that arrives during a poll is ignored. Later frames keep the control word captured at the accepted start, and no second poll follows.
- R11: The default control word 0x001_0005 gives one 8-bit command 0x05 per frame, with no address and no dummy phase.
- R12: A start that arrives in the cycle `done_o` is high is accepted, and a new poll begins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start request pulse |
| op_i | input | 2 | Finished operation: 0 none, 1 erase, 2 program, 3 status write |
| cfg_i | input | 28 | Control word, captured at an accepted start |
| sclk_o | output | 1 | Serial clock |
| cs_n_o | output | 1 | Chip select, active low |
| mosi_o | output | 1 | Serial data to the flash |
| miso_i | input | 1 | Serial data from the flash |
| busy_o | output | 1 | High while a poll is in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The completion pulse and the acceptance of a new start can fall in the same cycle. The bench provokes this by raising `start_i` with a different control word in the very cycle it sees `done_o` high. It then expects `busy_o` in the next cycle and a second poll whose frames match the new control word. A start raised in the middle of a poll, with another control word, is the opposite case. There the scoreboard must see only frames of the first word, and no poll after it.

// File: rtl/fip_pkg.sv
`timescale 1ns/1ps
package fip_pkg;
  localparam int CMD_MAX_BITS = 16;
  localparam int STAT_BITS    = 8;
  localparam int ALEN_W       = 2;
  localparam int DLEN_W       = 6;
  localparam int PCNT_W       = 6;
  localparam int CFG_W        = DLEN_W + 1 + ALEN_W + 1 + 1 + 1 + CMD_MAX_BITS;

  typedef enum logic [1:0] {
    OP_NONE    = 2'd0,
    OP_ERASE   = 2'd1,
    OP_PROGRAM = 2'd2,
    OP_WRSTAT  = 2'd3
  } fip_op_e;

  // control word layout, MSB first
  typedef struct packed {
    logic [DLEN_W-1:0]       dummy_len;  // [27:22]
    logic                    dummy_en;   // [21]
    logic [ALEN_W-1:0]       addr_len;   // [20:19]
    logic                    addr_en;    // [18]
    logic                    cmd16;      // [17]
    logic                    enable;     // [16]
    logic [CMD_MAX_BITS-1:0] cmd;        // [15:0]
  } fip_cfg_t;

  localparam logic [CFG_W-1:0] FIP_CFG_DEFAULT = 28'h001_0005;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_CMD   = 3'd1,
    PH_ADDR  = 3'd2,
    PH_DUMMY = 3'd3,
    PH_STAT  = 3'd4,
    PH_GAP   = 3'd5
  } fip_phase_e;
endpackage

// File: rtl/fip_sclk_gen.sv
`timescale 1ns/1ps
module fip_sclk_gen #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  output logic sclk_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CW-1:0] cnt_q;
  logic          sclk_q;
  logic          term;

  assign term = (cnt_q == CW'(HALF_DIV - 1));

  always_ff @(posedge clk) begin
    if (rst || !run_i) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else if (term) begin
      cnt_q  <= '0;
      sclk_q <= ~sclk_q;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  // strobes mark the cycle whose closing edge moves sclk
  assign rise_o = run_i && term && !sclk_q;
  assign fall_o = run_i && term && sclk_q;
  assign sclk_o = sclk_q;
endmodule

// File: rtl/fip_tx_shift.sv
`timescale 1ns/1ps
module fip_tx_shift #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  input  logic         shift_i,
  output logic         sd_o
);
  logic [W-1:0] sr_q;

  always_ff @(posedge clk) begin
    if (rst)          sr_q <= '0;
    else if (load_i)  sr_q <= val_i;
    else if (shift_i) sr_q <= {sr_q[W-2:0], 1'b0};
  end

  // zeros fill in behind the command, so address and dummy bits are 0
  assign sd_o = sr_q[W-1];
endmodule

// File: rtl/fip_rx_capture.sv
`timescale 1ns/1ps
module fip_rx_capture #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_i,
  input  logic         sample_i,
  input  logic         sd_i,
  output logic [W-1:0] data_o
);
  logic [W-1:0] sr_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i)  sr_q <= '0;
    else if (sample_i) sr_q <= {sr_q[W-2:0], sd_i};
  end

  assign data_o = sr_q;
endmodule

// File: rtl/flash_idle_poller.sv
`timescale 1ns/1ps
module flash_idle_poller
  import fip_pkg::*;
#(
  parameter int CLK_DIV  = 2,
  parameter int GAP_SCLK = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [1:0]       op_i,
  input  logic [CFG_W-1:0] cfg_i,
  output logic             sclk_o,
  output logic             cs_n_o,
  output logic             mosi_o,
  input  logic             miso_i,
  output logic             busy_o,
  output logic             done_o
);
  localparam int GAP_CYC = 2 * CLK_DIV * GAP_SCLK;
  localparam int GAP_W   = $clog2(GAP_CYC + 1);

  fip_phase_e          ph_q, ph_after;
  fip_cfg_t            cfg_q, cfg_in;
  logic [PCNT_W-1:0]   cnt_q;
  logic [GAP_W-1:0]    gap_q;
  logic                cs_q, busy_q, done_q;
  logic                run, rise, fall, accept;
  logic                load_tx, shift_tx, smp_rx;
  logic [CMD_MAX_BITS-1:0] tx_val;
  logic [STAT_BITS-1:0]    stat;
  logic                unused_stat_hi;

  assign cfg_in = fip_cfg_t'(cfg_i);

  function automatic logic [CMD_MAX_BITS-1:0] cmd_image(fip_cfg_t c);
    return c.cmd16 ? c.cmd : {c.cmd[7:0], 8'h00};
  endfunction

  function automatic fip_phase_e after_addr(fip_cfg_t c);
    return (c.dummy_en && (c.dummy_len != '0)) ? PH_DUMMY : PH_STAT;
  endfunction

  function automatic fip_phase_e after_cmd(fip_cfg_t c);
    return c.addr_en ? PH_ADDR : after_addr(c);
  endfunction

  function automatic logic [PCNT_W-1:0] len_m1(fip_phase_e p, fip_cfg_t c);
    case (p)
      PH_CMD:   return c.cmd16 ? PCNT_W'(CMD_MAX_BITS - 1) : PCNT_W'(7);
      PH_ADDR:  return PCNT_W'(c.addr_len);
      PH_DUMMY: return PCNT_W'(c.dummy_len) - PCNT_W'(1);
      default:  return PCNT_W'(STAT_BITS - 1);
    endcase
  endfunction

  assign run    = (ph_q == PH_CMD) || (ph_q == PH_ADDR) ||
                  (ph_q == PH_DUMMY) || (ph_q == PH_STAT);
  assign accept = start_i && (ph_q == PH_IDLE) && (op_i != OP_NONE);

  always_comb begin
    case (ph_q)
      PH_CMD:  ph_after = after_cmd(cfg_q);
      PH_ADDR: ph_after = after_addr(cfg_q);
      default: ph_after = PH_STAT;
    endcase
  end

  fip_sclk_gen #(.HALF_DIV(CLK_DIV)) u_sclk (
    .clk    (clk),
    .rst    (rst),
    .run_i  (run),
    .sclk_o (sclk_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  assign load_tx  = (accept && cfg_in.enable) || ((ph_q == PH_GAP) && (gap_q == '0));
  assign tx_val   = (ph_q == PH_IDLE) ? cmd_image(cfg_in) : cmd_image(cfg_q);
  assign shift_tx = fall && (ph_q == PH_CMD);
  assign smp_rx   = rise && (ph_q == PH_STAT);

  fip_tx_shift #(.W(CMD_MAX_BITS)) u_tx (
    .clk     (clk),
    .rst     (rst),
    .load_i  (load_tx),
    .val_i   (tx_val),
    .shift_i (shift_tx),
    .sd_o    (mosi_o)
  );

  fip_rx_capture #(.W(STAT_BITS)) u_rx (
    .clk      (clk),
    .rst      (rst),
    .clr_i    (load_tx),
    .sample_i (smp_rx),
    .sd_i     (miso_i),
    .data_o   (stat)
  );

  // only the write-in-progress flag steers the sequence
  assign unused_stat_hi = ^stat[STAT_BITS-1:1];

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q   <= PH_IDLE;
      cfg_q  <= fip_cfg_t'(FIP_CFG_DEFAULT);
      cnt_q  <= '0;
      gap_q  <= '0;
      cs_q   <= 1'b1;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (ph_q)
        PH_IDLE: begin
          if (accept) begin
            cfg_q <= cfg_in;
            if (cfg_in.enable) begin
              ph_q   <= PH_CMD;
              cnt_q  <= len_m1(PH_CMD, cfg_in);
              cs_q   <= 1'b0;
              busy_q <= 1'b1;
            end else begin
              done_q <= 1'b1;
            end
          end
        end
        PH_CMD, PH_ADDR, PH_DUMMY: begin
          if (fall) begin
            if (cnt_q == '0) begin
              ph_q  <= ph_after;
              cnt_q <= len_m1(ph_after, cfg_q);
            end else begin
              cnt_q <= cnt_q - 1'b1;
            end
          end
        end
        PH_STAT: begin
          if (fall) begin
            if (cnt_q == '0) begin
              cs_q <= 1'b1;
              if (stat[0]) begin
                ph_q  <= PH_GAP;
                gap_q <= GAP_W'(GAP_CYC - 1);
              end else begin
                ph_q   <= PH_IDLE;
                busy_q <= 1'b0;
                done_q <= 1'b1;
              end
            end else begin
              cnt_q <= cnt_q - 1'b1;
            end
          end
        end
        PH_GAP: begin
          if (gap_q == '0) begin
            ph_q  <= PH_CMD;
            cnt_q <= len_m1(PH_CMD, cfg_q);
            cs_q  <= 1'b0;
          end else begin
            gap_q <= gap_q - 1'b1;
          end
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign cs_n_o = cs_q;
  assign busy_o = busy_q;
  assign done_o = done_q;
endmodule

// File: rtl/fip_poller_chk.sv
`timescale 1ns/1ps
module fip_poller_chk
  import fip_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             sclk_o,
  input logic             cs_n_o,
  input logic             mosi_o,
  input logic             busy_o,
  input logic             done_o,
  input logic [CFG_W-1:0] cfg_q
);
  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R8
  done_not_busy_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);

  // R3
  idle_cs_high_chk: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> cs_n_o);

  // R9
  sclk_idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    cs_n_o |-> (!sclk_o && !mosi_o));

  // R4
  mosi_moves_low_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(mosi_o) |-> !sclk_o);

  // R10
  cfg_held_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_o && $past(busy_o)) |-> $stable(cfg_q));
endmodule

bind flash_idle_poller fip_poller_chk u_chk (
  .clk    (clk),
  .rst    (rst),
  .sclk_o (sclk_o),
  .cs_n_o (cs_n_o),
  .mosi_o (mosi_o),
  .busy_o (busy_o),
  .done_o (done_o),
  .cfg_q  (cfg_q)
);

// File: tb/flash_idle_poller_tb.sv
`timescale 1ns/1ps
module flash_idle_poller_tb;
  import fip_pkg::*;

  localparam int CLK_DIV  = 2;
  localparam int GAP_SCLK = 2;
  localparam int GAP_CYC  = 2 * CLK_DIV * GAP_SCLK;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, miso = 1'b0;
  logic [1:0] op = 2'd0;
  logic [CFG_W-1:0] cfg = '0;
  logic sclk, cs_n, mosi, busy, done;

  flash_idle_poller #(.CLK_DIV(CLK_DIV), .GAP_SCLK(GAP_SCLK)) u_dut (
    .clk(clk), .rst(rst), .start_i(start), .op_i(op), .cfg_i(cfg),
    .sclk_o(sclk), .cs_n_o(cs_n), .mosi_o(mosi), .miso_i(miso),
    .busy_o(busy), .done_o(done)
  );

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  bit mon_on = 1'b0;
  always @(posedge clk) cyc++;

  task automatic chk(string req, string what, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  typedef struct {
    int          nbits;
    int          hdr;
    logic [127:0] pat;
    bit          last;
    string       req;
  } frame_t;

  frame_t exp_q[$];
  logic [7:0] stat_q[$];

  // flash model
  logic [127:0] cap;
  int ncap = 0, cur_hdr = 0;
  logic [7:0] cur_stat = 8'h00;

  always @(negedge cs_n) begin
    cap = '0; ncap = 0; miso = 1'b0;
    cur_hdr  = (exp_q.size() > 0) ? exp_q[0].hdr : 0;
    cur_stat = (stat_q.size() > 0) ? stat_q.pop_front() : 8'h00;
  end
  always @(posedge sclk) if (cs_n === 1'b0) begin
    cap = {cap[126:0], mosi}; ncap++;
  end
  always @(negedge sclk) if (cs_n === 1'b0) begin
    if (ncap >= cur_hdr && ncap - cur_hdr < 8) miso = cur_stat[7 - (ncap - cur_hdr)];
  end

  // monitor / scoreboard
  always @(posedge cs_n) if (mon_on) begin
    frame_t e;
    int t_end;
    t_end = cyc;
    if (exp_q.size() == 0) begin
      chk("R10", "unexpected frame", 1, 0);
    end else begin
      e = exp_q.pop_front();
      chk(e.req, "frame bit count", ncap, e.nbits);
      chk(e.req, "frame mosi bits", cap, e.pat);
      @(negedge clk);
      chk("R8", "done at frame end", done, e.last);
      chk("R8", "busy at frame end", busy, !e.last);
      chk("R9", "sclk/mosi idle after frame", {sclk, mosi}, 2'b00);
      if (e.last) begin
        @(negedge clk);
        chk("R8", "done one cycle", done, 0);
      end else begin
        @(negedge cs_n);
        chk("R7", "cs high gap ok", (cyc - t_end) >= GAP_CYC, 1);
      end
    end
  end

  always @(posedge sclk) if (mon_on) begin
    int t0;
    t0 = cyc;
    @(negedge sclk);
    chk("R9", "sclk high time", cyc - t0, CLK_DIV);
  end

  task automatic queue_poll(string req, logic [CFG_W-1:0] c, int nbusy, logic [7:0] idle_stat);
    fip_cfg_t f;
    int cb, ab, db;
    logic [127:0] pat;
    logic [15:0] cw;
    f  = fip_cfg_t'(c);
    cb = f.cmd16 ? 16 : 8;
    ab = f.addr_en ? int'(f.addr_len) + 1 : 0;
    db = f.dummy_en ? int'(f.dummy_len) : 0;
    cw = f.cmd16 ? f.cmd : {8'h00, f.cmd[7:0]};
    pat = {112'b0, cw} << (ab + db + 8);
    for (int i = 0; i < nbusy; i++) begin
      stat_q.push_back(8'h01 | 8'(i * 8'h42));
      exp_q.push_back('{cb + ab + db + 8, cb + ab + db, pat, 1'b0, req});
    end
    stat_q.push_back(idle_stat);
    exp_q.push_back('{cb + ab + db + 8, cb + ab + db, pat, 1'b1, req});
  endtask

  task automatic pulse_start(string req, logic [CFG_W-1:0] c, logic [1:0] o);
    @(negedge clk); cfg = c; op = o; start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(req, "busy after start", busy, 1);
    chk(req, "cs low after start", cs_n, 0);
  endtask

  task automatic wait_done(string req);
    int n;
    n = 0;
    while (done !== 1'b1 && n < 20000) begin @(negedge clk); n++; end
    chk(req, "poll completed", done, 1);
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
    chk("R7", "scoreboard drained", exp_q.size(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    fip_cfg_t c;
    bit saw;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "reset outputs {cs,sclk,mosi,busy,done}", {cs_n, sclk, mosi, busy, done}, 5'b10000);
    mon_on = 1'b1;

    // R2: op code 0 has no effect
    @(negedge clk); cfg = FIP_CFG_DEFAULT; op = OP_NONE; start = 1'b1;
    @(negedge clk); start = 1'b0;
    saw = 1'b0;
    repeat (30) begin
      if (done || busy || !cs_n) saw = 1'b1;
      @(negedge clk);
    end
    chk("R2", "op 0 ignored", saw, 0);

    // R11: default control word
    queue_poll("R11", FIP_CFG_DEFAULT, 0, 8'h00);
    pulse_start("R11", FIP_CFG_DEFAULT, OP_ERASE);
    wait_done("R11");
    settle();

    // R4 R5 R6 R7 R8: 16-bit command, 4 address bits, 5 dummy, two busy reads, idle 0xFE
    c = '0; c.enable = 1; c.cmd16 = 1; c.cmd = 16'hA5C3;
    c.addr_en = 1; c.addr_len = 2'd3; c.dummy_en = 1; c.dummy_len = 6'd5;
    queue_poll("R4", c, 2, 8'hFE);
    pulse_start("R4", c, OP_PROGRAM);
    wait_done("R7");
    settle();

    // R5 R6: address disabled with nonzero length, dummy enabled with length 0, 8-bit mode
    c = '0; c.enable = 1; c.cmd16 = 0; c.cmd = 16'hBE05;
    c.addr_en = 0; c.addr_len = 2'd3; c.dummy_en = 1; c.dummy_len = 6'd0;
    queue_poll("R5", c, 1, 8'h00);
    pulse_start("R5", c, OP_WRSTAT);
    wait_done("R5");
    settle();

    // R6: one address bit, maximum dummy length
    c = '0; c.enable = 1; c.cmd = 16'h0070;
    c.addr_en = 1; c.addr_len = 2'd0; c.dummy_en = 1; c.dummy_len = 6'd63;
    queue_poll("R6", c, 0, 8'h80);
    pulse_start("R6", c, OP_ERASE);
    wait_done("R6");
    settle();

    // R3: enable clear
    c = fip_cfg_t'(FIP_CFG_DEFAULT); c.enable = 0;
    @(negedge clk); cfg = c; op = OP_WRSTAT; start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R3", "done right after start", done, 1);
    chk("R3", "busy stays low", busy, 0);
    chk("R3", "cs stays high", cs_n, 1);
    @(negedge clk);
    chk("R3", "done one cycle", done, 0);
    saw = 1'b0;
    repeat (20) begin
      if (!cs_n || busy) saw = 1'b1;
      @(negedge clk);
    end
    chk("R3", "no serial traffic", saw, 0);

    // R10: start during a poll is ignored
    c = '0; c.enable = 1; c.cmd = 16'h0005; c.addr_en = 1; c.addr_len = 2'd1;
    fork
      begin
        queue_poll("R10", c, 2, 8'h00);
        pulse_start("R10", c, OP_ERASE);
        wait_done("R10");
      end
      begin
        fip_cfg_t o;
        wait (busy === 1'b1);
        repeat (12) @(negedge clk);
        o = '0; o.enable = 1; o.cmd16 = 1; o.cmd = 16'h9F9F; o.dummy_en = 1; o.dummy_len = 6'd3;
        cfg = o; op = OP_PROGRAM; start = 1'b1;
        @(negedge clk); start = 1'b0;
      end
    join
    saw = 1'b0;
    repeat (30) begin
      @(negedge clk);
      if (busy || !cs_n) saw = 1'b1;
    end
    chk("R10", "no deferred poll", saw, 0);
    settle();

    // R12: start in the cycle done is high
    c = fip_cfg_t'(FIP_CFG_DEFAULT);
    queue_poll("R12", c, 1, 8'h00);
    pulse_start("R12", c, OP_ERASE);
    wait_done("R12");
    c.cmd16 = 1; c.cmd = 16'h1234;
    queue_poll("R12", c, 0, 8'h02);
    cfg = c; op = OP_PROGRAM; start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R12", "start in done cycle accepted", busy, 1);
    @(negedge clk);
    wait_done("R12");
    settle();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule